// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a logical address into a physical one for a machine that divides memory into segments. The processor presents a segment index and an offset inside that segment. The translator first compares the index against a programmed segment count. If the index is in range, the block reads the segment's descriptor from a table in memory and compares the offset against the segment length. It then returns either the physical address (segment origin plus offset) or a fault with a reason code.

The descriptor table sits in ordinary memory. A programmable table-origin register gives its location. Each entry takes eight bytes: the segment origin word at the lower address and the segment length word four bytes above it. The two words come through a single read port, one after the other. The table-origin register and the segment-count register can only be written while the privilege input is high. An unprivileged write leaves both registers unchanged and raises an error pulse.

Only one translation is in flight at a time. The request port stays not-ready from acceptance until the response has been delivered.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `req_ready` is high and `rsp_valid`, `mem_req` and `cfg_err` are low. Both the table origin and the segment count are zero, so any request faults with code 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the response for that request has been delivered.
- R3: If the segment index is not below the segment count, the response has `rsp_fault`=1 and `rsp_code`=1. No memory read is issued for that request.
- R4: For a legal index s, exactly two reads are issued. The first is at table origin + 8*s and returns the segment origin. The second follows immediately and is at that address + 4; it returns the segment length.
- R5: If the offset is greater than or equal to the segment length, the response has `rsp_fault`=1, `rsp_code`=2 and `rsp_paddr`=0. An offset of length-1 is legal. A length of 0 rejects every offset.
- R6: A legal translation responds with `rsp_fault`=0, `rsp_code`=0 and `rsp_paddr` equal to the segment origin plus the zero-extended offset, taken modulo 2^32.
- R7: A write with `cfg_we`=1 and `priv`=1 updates one register on that edge. `cfg_sel`=0 selects the table origin, which takes all 32 bits of `cfg_wdata`. `cfg_sel`=1 selects the segment count, which takes the low SEG_W+1 bits.
- R8: A write with `cfg_we`=1 and `priv`=0 changes neither register. `cfg_err` is high for exactly the cycle after that edge; it is low after a privileged write.
- R9: While `mem_req` is high and `mem_rvalid` is low, `mem_req` stays high and `mem_addr` stays unchanged on the next cycle. A read completes on an edge where both are high.
- R10: `rsp_valid` is high for exactly one cycle, and `req_ready` is high in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv | input | 1 | Privileged mode; gates configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: table origin, 1: segment count |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_err | output | 1 | Pulse: unprivileged write was dropped |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translator idle, can take a request |
| req_seg | input | SEG_W | Segment index |
| req_off | input | OFF_W | Offset within segment |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_fault | output | 1 | Response is a fault |
| rsp_code | output | 2 | 0 ok, 1 bad segment, 2 offset over length |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| mem_req | output | 1 | Descriptor read request, held until accepted |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_rvalid | input | 1 | Read data valid; completes the read |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest case to reach from the ports is a dropped configuration write whose only visible effect is a read that did not move. An unprivileged write to the table origin changes no response code. The bench therefore predicts every descriptor address from its own shadow registers and checks it at the memory port, so a read at the new origin would show up there.

It also drives memory latencies of zero and several cycles, which tests the hold of the read address between the origin fetch and the length fetch. Separate cases cover offsets at length-1 and at the length itself, a zero-length segment, and origin-plus-offset wrapping past 2^32.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int ADDR_W     = 32;
  localparam int DESC_BYTES = 8;
  localparam int WORD_BYTES = 4;

  typedef enum logic [5:0] {
    ST_IDLE        = 6'b000001,
    ST_CHECK_SEG   = 6'b000010,
    ST_FETCH_ORG   = 6'b000100,
    ST_FETCH_LEN   = 6'b001000,
    ST_CHECK_OFF   = 6'b010000,
    ST_RESPOND     = 6'b100000
  } xl_state_e;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_SEG  = 2'd1,
    FC_OFF  = 2'd2
  } fault_code_e;

  function automatic logic [ADDR_W-1:0] entry_addr(
    input logic [ADDR_W-1:0] origin,
    input logic [ADDR_W-1:0] seg_idx,
    input logic              len_word
  );
    logic [ADDR_W-1:0] stride;
    stride = seg_idx * ADDR_W'(DESC_BYTES);
    return origin + stride + (len_word ? ADDR_W'(WORD_BYTES) : '0);
  endfunction

  function automatic logic [ADDR_W-1:0] phys_of(
    input logic [ADDR_W-1:0] seg_origin,
    input logic [ADDR_W-1:0] offset
  );
    return seg_origin + offset;
  endfunction

  function automatic logic below(
    input logic [ADDR_W-1:0] value,
    input logic [ADDR_W-1:0] bound
  );
    return value < bound;
  endfunction

endpackage

// File: rtl/seg_xlate_cfg.sv
module seg_xlate_cfg
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              priv,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] tbl_origin,
  output logic [SEG_W:0]    seg_count,
  output logic              cfg_err,
  output logic              cfg_dropped
);

  logic cfg_taken;

  assign cfg_taken   = cfg_we && priv;
  assign cfg_dropped = cfg_we && !priv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_origin <= '0;
      seg_count  <= '0;
      cfg_err    <= 1'b0;
    end else begin
      cfg_err <= cfg_dropped;
      if (cfg_taken) begin
        if (cfg_sel) seg_count  <= cfg_wdata[SEG_W:0];
        else         tbl_origin <= cfg_wdata;
      end
    end
  end

endmodule

// File: rtl/seg_xlate_fsm.sv
module seg_xlate_fsm
  import seg_xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      seg_ok,
  input  logic      off_ok,
  input  logic      mem_rvalid,
  output xl_state_e state,
  output logic      req_ready,
  output logic      req_accept,
  output logic      mem_req,
  output logic      rsp_valid,
  output logic      seg_reject,
  output logic      off_reject,
  output logic      org_done,
  output logic      len_done
);

  xl_state_e state_d;

  assign req_ready  = (state == ST_IDLE);
  assign req_accept = req_ready && req_valid;
  assign mem_req    = (state == ST_FETCH_ORG) || (state == ST_FETCH_LEN);
  assign rsp_valid  = (state == ST_RESPOND);
  assign seg_reject = (state == ST_CHECK_SEG) && !seg_ok;
  assign off_reject = (state == ST_CHECK_OFF) && !off_ok;
  assign org_done   = (state == ST_FETCH_ORG) && mem_rvalid;
  assign len_done   = (state == ST_FETCH_LEN) && mem_rvalid;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:      if (req_valid) state_d = ST_CHECK_SEG;
      ST_CHECK_SEG: state_d = seg_ok ? ST_FETCH_ORG : ST_RESPOND;
      ST_FETCH_ORG: if (mem_rvalid) state_d = ST_FETCH_LEN;
      ST_FETCH_LEN: if (mem_rvalid) state_d = ST_CHECK_OFF;
      ST_CHECK_OFF: state_d = ST_RESPOND;
      ST_RESPOND:   state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 6,
  parameter int OFF_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xl_state_e         state,
  input  logic              req_accept,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [ADDR_W-1:0] tbl_origin,
  input  logic [SEG_W:0]    seg_count,
  input  logic              org_done,
  input  logic              len_done,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              seg_ok,
  output logic              off_ok,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rsp_fault,
  output logic [1:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_paddr
);

  logic [SEG_W-1:0]  seg_q;
  logic [OFF_W-1:0]  off_q;
  logic [ADDR_W-1:0] org_q;
  logic [ADDR_W-1:0] len_q;
  fault_code_e       code_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [ADDR_W-1:0] seg_wide;
  logic [ADDR_W-1:0] off_wide;

  assign seg_wide = ADDR_W'(seg_q);
  assign off_wide = ADDR_W'(off_q);
  assign seg_ok   = below(seg_wide, ADDR_W'(seg_count));
  assign off_ok   = below(off_wide, len_q);
  assign mem_addr = entry_addr(tbl_origin, seg_wide, state == ST_FETCH_LEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q   <= '0;
      off_q   <= '0;
      org_q   <= '0;
      len_q   <= '0;
      code_q  <= FC_NONE;
      paddr_q <= '0;
    end else begin
      if (req_accept) begin
        seg_q   <= req_seg;
        off_q   <= req_off;
        code_q  <= FC_NONE;
        paddr_q <= '0;
      end
      if (state == ST_CHECK_SEG && !seg_ok) code_q <= FC_SEG;
      if (org_done) org_q <= mem_rdata;
      if (len_done) len_q <= mem_rdata;
      if (state == ST_CHECK_OFF) begin
        code_q  <= off_ok ? FC_NONE : FC_OFF;
        paddr_q <= off_ok ? phys_of(org_q, off_wide) : '0;
      end
    end
  end

  assign rsp_fault = (code_q != FC_NONE);
  assign rsp_code  = code_q;
  assign rsp_paddr = paddr_q;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 6,
  parameter int OFF_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             priv,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic             cfg_err,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_code,
  output logic [31:0]      rsp_paddr,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata
);

  logic [ADDR_W-1:0] tbl_origin;
  logic [SEG_W:0]    seg_count;
  logic              cfg_dropped;
  xl_state_e         state;
  logic              req_accept;
  logic              seg_ok;
  logic              off_ok;
  logic              seg_reject;
  logic              off_reject;
  logic              org_done;
  logic              len_done;

  seg_xlate_cfg #(.SEG_W(SEG_W)) cfg_u (
    .clk(clk), .rst_n(rst_n), .priv(priv), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .tbl_origin(tbl_origin),
    .seg_count(seg_count), .cfg_err(cfg_err), .cfg_dropped(cfg_dropped)
  );

  seg_xlate_fsm fsm_u (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .seg_ok(seg_ok),
    .off_ok(off_ok), .mem_rvalid(mem_rvalid), .state(state),
    .req_ready(req_ready), .req_accept(req_accept), .mem_req(mem_req),
    .rsp_valid(rsp_valid), .seg_reject(seg_reject), .off_reject(off_reject),
    .org_done(org_done), .len_done(len_done)
  );

  seg_xlate_dp #(.SEG_W(SEG_W), .OFF_W(OFF_W)) dp_u (
    .clk(clk), .rst_n(rst_n), .state(state), .req_accept(req_accept),
    .req_seg(req_seg), .req_off(req_off), .tbl_origin(tbl_origin),
    .seg_count(seg_count), .org_done(org_done), .len_done(len_done),
    .mem_rdata(mem_rdata), .seg_ok(seg_ok), .off_ok(off_ok),
    .mem_addr(mem_addr), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
    .rsp_paddr(rsp_paddr)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_xlate_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        priv,
  input logic        cfg_we,
  input logic        cfg_err,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [1:0]  rsp_code,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic [5:0]  state_bits,
  input logic        seg_reject,
  input logic        off_reject,
  input logic        org_done
);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R2
  state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_bits) == 1);

  // R3
  seg_fault_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_reject |=> rsp_valid && rsp_fault && rsp_code == 2'd1 && !mem_req);

  // R4
  len_read_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    org_done |=> mem_req && mem_addr == $past(mem_addr) + 32'd4);

  // R5
  off_fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_reject |=> rsp_valid && rsp_code == 2'd2);

  // R6
  ok_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_code == 2'd0);

  // R8
  dropped_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !priv |=> cfg_err);

  // R8
  taken_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && priv |=> !cfg_err);

  // R9
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

endmodule

bind seg_xlate seg_xlate_chk chk_i (
  .clk(clk), .rst_n(rst_n), .priv(priv), .cfg_we(cfg_we), .cfg_err(cfg_err),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_code(rsp_code), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .state_bits(state),
  .seg_reject(seg_reject), .off_reject(off_reject), .org_done(org_done)
);

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;

  localparam int SEG_W = 6;
  localparam int OFF_W = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             priv = 1'b0;
  logic             cfg_we = 1'b0;
  logic             cfg_sel = 1'b0;
  logic [31:0]      cfg_wdata = '0;
  logic             cfg_err;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic             rsp_valid;
  logic             rsp_fault;
  logic [1:0]       rsp_code;
  logic [31:0]      rsp_paddr;
  logic             mem_req;
  logic [31:0]      mem_addr;
  logic             mem_rvalid = 1'b0;
  logic [31:0]      mem_rdata = '0;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .priv(priv), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_err(cfg_err), .req_valid(req_valid),
    .req_ready(req_ready), .req_seg(req_seg), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
    .rsp_paddr(rsp_paddr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // shadow model
  logic [31:0] mem_m [logic [31:0]];
  logic [31:0] sh_origin = '0;
  logic [31:0] sh_count = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : 32'd0;
  endfunction

  // scoreboard
  logic [34:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] addr_q[$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check("R2 unexpected response", 1, 0);
      else begin
        logic [34:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {29'd0, rsp_fault, rsp_code, rsp_paddr}, {29'd0, e});
      end
    end
  end

  // memory model
  int lat_cfg = 1;
  int wcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 1'b0;
      wcnt = 0;
    end else if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat_cfg) begin
        if (addr_q.size() == 0) check("R3 read issued when none expected", {32'd0, mem_addr}, 64'hFFFF_FFFF);
        else check("R4 descriptor address", {32'd0, mem_addr}, {32'd0, addr_q.pop_front()});
        mem_rdata = rd(mem_addr);
        mem_rvalid = 1'b1;
      end else wcnt++;
    end
  end

  task automatic cfg_wr(input bit p, input bit sel, input logic [31:0] d);
    @(negedge clk);
    priv = p; cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; priv = 1'b0;
    check(p ? "R7 cfg_err quiet on privileged write" : "R8 cfg_err on dropped write",
          {63'd0, cfg_err}, {63'd0, !p});
    if (p) begin
      if (sel) sh_count = d & 32'h7F;
      else     sh_origin = d;
    end
  endtask

  task automatic xlate(input string req, input logic [SEG_W-1:0] s, input logic [OFF_W-1:0] o);
    logic [31:0] da, org, len;
    if (32'(s) >= sh_count) begin
      exp_q.push_back({1'b1, 2'd1, 32'd0});
    end else begin
      da = sh_origin + 32'(s) * 32'd8;
      addr_q.push_back(da);
      addr_q.push_back(da + 32'd4);
      org = rd(da);
      len = rd(da + 32'd4);
      if (32'(o) < len) exp_q.push_back({1'b0, 2'd0, org + 32'(o)});
      else              exp_q.push_back({1'b1, 2'd2, 32'd0});
    end
    tag_q.push_back(req);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_off = o;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 ready low while busy", {63'd0, req_ready}, 64'd0);
    while (!rsp_valid) @(negedge clk);
    @(negedge clk);
    check("R10 ready back after response", {63'd0, req_ready}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ready", {63'd0, req_ready}, 64'd1);
    check("R1 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check("R1 reset mem_req", {63'd0, mem_req}, 64'd0);
    check("R1 reset cfg_err", {63'd0, cfg_err}, 64'd0);
    rst_n = 1'b1;
    xlate("R1 count zero after reset faults", 6'd0, 20'd5);

    cfg_wr(1'b0, 1'b1, 32'd4);
    xlate("R8 dropped count write ignored", 6'd0, 20'd5);

    cfg_wr(1'b1, 1'b0, 32'h0000_1000);
    cfg_wr(1'b1, 1'b1, 32'd4);
    mem_m[32'h1000] = 32'h0004_0000; mem_m[32'h1004] = 32'h100;
    mem_m[32'h1008] = 32'h0008_0000; mem_m[32'h100C] = 32'h0;
    mem_m[32'h1010] = 32'hFFFF_FFF0; mem_m[32'h1014] = 32'h1000;
    mem_m[32'h1018] = 32'h0010_0000; mem_m[32'h101C] = 32'hF_FFFF;

    xlate("R6 legal translation seg0", 6'd0, 20'h20);
    xlate("R5 offset length-1 legal", 6'd0, 20'hFF);
    xlate("R5 offset equal length faults", 6'd0, 20'h100);
    xlate("R5 zero length faults", 6'd1, 20'd0);
    xlate("R6 wrap past 2^32", 6'd2, 20'h20);
    xlate("R3 index equal count faults", 6'd4, 20'd0);
    xlate("R3 top index faults", 6'd63, 20'd1);
    lat_cfg = 0;
    xlate("R9 zero latency read", 6'd3, 20'hF_FFFE);
    lat_cfg = 4;
    xlate("R9 slow memory read", 6'd3, 20'h12345);

    cfg_wr(1'b0, 1'b0, 32'h0000_8000);
    lat_cfg = 1;
    xlate("R8 dropped origin write ignored", 6'd0, 20'h10);

    mem_m[32'h2008] = 32'h00AA_0000; mem_m[32'h200C] = 32'h40;
    cfg_wr(1'b1, 1'b0, 32'h0000_2000);
    cfg_wr(1'b1, 1'b1, 32'h0000_0082);
    xlate("R7 new origin and masked count", 6'd1, 20'h3F);
    xlate("R7 masked count bounds index", 6'd2, 20'h0);

    repeat (3) @(negedge clk);
    check("R4 no leftover reads", 64'(addr_q.size()), 64'd0);
    check("R2 no leftover responses", 64'(exp_q.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule